// File: doc/BRIEF.md
# Write-Through Line Cache

This block is a set-associative read cache placed in an existing path between a narrow requester and a wide memory. Each cache line holds exactly one memory word. Several requester words sit side by side in one memory word, so the low bits of a requester address pick a word inside the line and the upper bits form the memory word address. A read that hits returns its word from the line store without a memory access. A read that misses issues a single memory read for the line, stores the returned line in the least-recently-used way of its set, and returns the requested word from the memory data in the same cycle.

Writes always go through to memory. The requester's byte enables are moved to the position of the addressed word within the memory byte-enable vector. A write that hits also merges its bytes into the cached line. A write that misses leaves the cache unchanged. Requests enter a buffer and are retired one at a time from its head, so responses come back in request order. With `PENDING = 1` the buffer is a single register, which keeps `up_rdy` a flop output but caps acceptance at one request every two cycles. Larger values give a small ring that is rounded up to a power of two and accepts one request per cycle.

Top module: `wtc_cache`

## Requirements
- R1: A read whose line is cached raises `up_rvalid` with the addressed word on `up_rdata` and makes no memory request.
- R2: A read miss issues exactly one memory read with `dn_addr` = requester address / (MEM_W/CPU_W), returns the word taken from `dn_rdata` when `dn_rvalid` is high, and later reads of that line hit.
- R3: Requester address a selects bits [CPU_W*(a mod R)+CPU_W-1 : CPU_W*(a mod R)] of memory word a / R, where R = MEM_W/CPU_W, so words are packed in ascending order.
- R4: Every accepted write produces one memory write to its line address, with `dn_wdata` holding the write data copied into every word slot. A write hit updates the enabled bytes of the cached line.
- R5: A write miss allocates no line, so the next read of that line misses.
- R6: `dn_be` equals `up_be` shifted left by CPU_W/8 × (a mod R) bits, and all its other bits are zero.
- R7: Read data returns in the order in which the requests were accepted.
- R8: On a miss the line goes to an invalid way if the set has one. Otherwise it goes to the way least recently touched by a hit or a fill.
- R9: `dn_req` is high only while `dn_rdy` is high, and after a memory read is issued no further memory request is made until its data has returned.
- R10: With `PENDING` >= 2, a stream of read hits is accepted on every cycle (`up_rdy` stays high).
- R11: With `PENDING` = 1, `up_rdy` is low in the cycle after an acceptance, so at most one request is accepted every two cycles.
- R12: Synchronous active-high `rst` invalidates every line. In the cycle after reset, `up_rdy` is high and `up_rvalid` and `dn_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Requester request valid |
| up_wr | input | 1 | 1 = write, 0 = read |
| up_addr | input | $clog2(MEM_W/CPU_W)+MEM_AW | Requester word address |
| up_wdata | input | CPU_W | Write data |
| up_be | input | CPU_W/8 | Write byte enables |
| up_rdy | output | 1 | Request accepted when high together with `up_req` |
| up_rvalid | output | 1 | Read data strobe |
| up_rdata | output | CPU_W | Read data |
| dn_req | output | 1 | Memory request |
| dn_wr | output | 1 | Memory write when high |
| dn_addr | output | MEM_AW | Memory word (line) address |
| dn_wdata | output | MEM_W | Memory write data |
| dn_be | output | MEM_W/8 | Memory byte enables |
| dn_rdy | input | 1 | Memory can take a request |
| dn_rvalid | input | 1 | Memory read data strobe |
| dn_rdata | input | MEM_W | Memory read data |

## Verification
The bench builds the main instance with 32-bit requester words, 128-bit lines, 8 lines in 2 ways and 8-bit memory addresses. With these values four words share a line and four sets each hold two lines, so three lines mapped to one set force evictions and expose the LRU order within a short sequence. It also reaches the last word of the address space, and all four byte-enable positions appear. The memory model answers after two cycles and drops `dn_rdy` on every third cycle. A second instance built with `PENDING = 1` and fed a stream of writes measures the halved acceptance rate, while the main instance (`PENDING = 2`) takes back-to-back hits.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic {
        ST_SERVE = 1'b0,
        ST_AWAIT = 1'b1
    } ctl_state_e;

    // index width that never collapses to zero
    function automatic int clog2_min1(input int value);
        return (value <= 2) ? 1 : $clog2(value);
    endfunction

endpackage

// File: rtl/wtc_req_buf.sv
module wtc_req_buf
    import wtc_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         in_rdy,
    output logic         out_vld,
    output logic [W-1:0] dout,
    input  logic         pop
);

    generate
        if (DEPTH <= 1) begin : g_single
            logic         full_q;
            logic [W-1:0] data_q;

            assign in_rdy  = !full_q;
            assign out_vld = full_q;
            assign dout    = data_q;

            always_ff @(posedge clk) begin
                if (rst)                  full_q <= 1'b0;
                else if (push && !full_q) full_q <= 1'b1;
                else if (pop)             full_q <= 1'b0;
            end

            always_ff @(posedge clk) begin
                if (push && !full_q) data_q <= din;
            end
        end else begin : g_ring
            localparam int PW    = clog2_min1(DEPTH);
            localparam int SLOTS = 1 << PW;

            logic [W-1:0]  slot_q [SLOTS];
            logic [PW-1:0] wp_q, rp_q;
            logic [PW:0]   cnt_q;
            logic          do_push, do_pop;

            assign in_rdy  = (cnt_q != (PW+1)'(SLOTS));
            assign out_vld = (cnt_q != '0);
            assign dout    = slot_q[rp_q];
            assign do_push = push && in_rdy;
            assign do_pop  = pop && out_vld;

            always_ff @(posedge clk) begin
                if (rst) begin
                    wp_q  <= '0;
                    rp_q  <= '0;
                    cnt_q <= '0;
                end else begin
                    if (do_push) begin
                        slot_q[wp_q] <= din;
                        wp_q         <= wp_q + 1'b1;
                    end
                    if (do_pop) rp_q <= rp_q + 1'b1;
                    cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wtc_tags.sv
module wtc_tags
    import wtc_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = clog2_min1(WAYS),
    localparam int SET_W = clog2_min1(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             upd_en,
    input  logic             upd_fill,
    input  logic [WAY_W-1:0] upd_way,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim
);

    logic [TAG_W-1:0] tag_q   [WAYS][SETS];
    logic             valid_q [WAYS][SETS];
    logic [WAY_W-1:0] age_q   [WAYS][SETS];
    logic [WAY_W-1:0] touched_age;
    logic             free_found;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[w][set_idx] && tag_q[w][set_idx] == tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // empty way first, otherwise the oldest rank
    always_comb begin
        victim     = '0;
        free_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!free_found && !valid_q[w][set_idx]) begin
                victim     = WAY_W'(w);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[w][set_idx] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end

    assign touched_age = age_q[upd_way][set_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    valid_q[w][s] <= 1'b0;
                    age_q[w][s]   <= WAY_W'(w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[w][set_idx] < touched_age)
                    age_q[w][set_idx] <= age_q[w][set_idx] + 1'b1;
            end
            age_q[upd_way][set_idx] <= '0;
            if (upd_fill) begin
                valid_q[upd_way][set_idx] <= 1'b1;
                tag_q[upd_way][set_idx]   <= tag;
            end
        end
    end

endmodule

// File: rtl/wtc_lines.sv
module wtc_lines
    import wtc_pkg::*;
#(
    parameter int WAYS   = 2,
    parameter int SETS   = 4,
    parameter int LINE_W = 128,
    localparam int WAY_W = clog2_min1(WAYS),
    localparam int SET_W = clog2_min1(SETS),
    localparam int NB    = LINE_W / 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [SET_W-1:0]  rd_set,
    output logic [LINE_W-1:0] rd_data
);

    logic [LINE_W-1:0] line_q [WAYS][SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) line_q[wr_way][wr_set][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    assign rd_data = line_q[rd_way][rd_set];

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int LINES   = 8,
    parameter int WAYS    = 2,
    parameter int CPU_W   = 32,
    parameter int MEM_AW  = 8,
    parameter int MEM_W   = 128,
    parameter int PENDING = 2,
    localparam int RATIO     = MEM_W / CPU_W,
    localparam int SEL_W     = $clog2(RATIO),
    localparam int CPU_AW    = SEL_W + MEM_AW,
    localparam int CPU_BYTES = CPU_W / 8,
    localparam int MEM_BYTES = MEM_W / 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 up_req,
    input  logic                 up_wr,
    input  logic [CPU_AW-1:0]    up_addr,
    input  logic [CPU_W-1:0]     up_wdata,
    input  logic [CPU_BYTES-1:0] up_be,
    output logic                 up_rdy,
    output logic                 up_rvalid,
    output logic [CPU_W-1:0]     up_rdata,
    output logic                 dn_req,
    output logic                 dn_wr,
    output logic [MEM_AW-1:0]    dn_addr,
    output logic [MEM_W-1:0]     dn_wdata,
    output logic [MEM_BYTES-1:0] dn_be,
    input  logic                 dn_rdy,
    input  logic                 dn_rvalid,
    input  logic [MEM_W-1:0]     dn_rdata
);

    localparam int SETS  = LINES / WAYS;
    localparam int SET_W = clog2_min1(SETS);
    localparam int TAG_W = MEM_AW - $clog2(SETS);
    localparam int WAY_W = clog2_min1(WAYS);
    localparam int IDX_W = clog2_min1(RATIO);

    typedef struct packed {
        logic                 wr;
        logic [CPU_AW-1:0]    addr;
        logic [CPU_W-1:0]     wdata;
        logic [CPU_BYTES-1:0] be;
    } pend_t;

    pend_t                in_pend, head;
    logic [$bits(pend_t)-1:0] head_bits;
    logic                 head_vld, pop;
    logic [IDX_W-1:0]     word_idx;
    logic [MEM_AW-1:0]    line_addr;
    logic [SET_W-1:0]     set_idx;
    logic [TAG_W-1:0]     tag;
    logic                 hit, upd_en, upd_fill, ln_wr;
    logic [WAY_W-1:0]     hit_way, victim, upd_way, ln_way;
    logic [MEM_W-1:0]     rd_line, ln_data;
    logic [MEM_BYTES-1:0] ln_be;
    ctl_state_e           state_q, state_d;

    assign in_pend = '{wr: up_wr, addr: up_addr, wdata: up_wdata, be: up_be};

    wtc_req_buf #(.W($bits(pend_t)), .DEPTH(PENDING)) u_buf (
        .clk(clk), .rst(rst), .push(up_req), .din(in_pend), .in_rdy(up_rdy),
        .out_vld(head_vld), .dout(head_bits), .pop(pop)
    );

    assign head      = pend_t'(head_bits);
    assign word_idx  = IDX_W'(head.addr % RATIO);
    assign line_addr = MEM_AW'(head.addr / RATIO);
    assign set_idx   = SET_W'(line_addr % SETS);
    assign tag       = TAG_W'(line_addr / SETS);

    wtc_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .set_idx(set_idx), .tag(tag), .upd_en(upd_en),
        .upd_fill(upd_fill), .upd_way(upd_way), .hit(hit), .hit_way(hit_way),
        .victim(victim)
    );

    wtc_lines #(.WAYS(WAYS), .SETS(SETS), .LINE_W(MEM_W)) u_lines (
        .clk(clk), .wr_en(ln_wr), .wr_way(ln_way), .wr_set(set_idx),
        .wr_data(ln_data), .wr_be(ln_be), .rd_way(hit_way), .rd_set(set_idx),
        .rd_data(rd_line)
    );

    always_comb begin
        dn_req    = 1'b0;
        dn_wr     = head.wr;
        dn_addr   = line_addr;
        dn_wdata  = {RATIO{head.wdata}};
        dn_be     = MEM_BYTES'(head.be) << (word_idx * CPU_BYTES);
        up_rvalid = 1'b0;
        up_rdata  = rd_line[word_idx*CPU_W +: CPU_W];
        pop       = 1'b0;
        upd_en    = 1'b0;
        upd_fill  = 1'b0;
        upd_way   = hit_way;
        ln_wr     = 1'b0;
        ln_way    = hit_way;
        ln_data   = dn_wdata;
        ln_be     = dn_be;
        state_d   = state_q;
        case (state_q)
            ST_SERVE: begin
                if (head_vld && head.wr) begin
                    dn_req = dn_rdy;
                    if (dn_rdy) begin
                        pop    = 1'b1;
                        upd_en = hit;
                        ln_wr  = hit;
                    end
                end else if (head_vld && hit) begin
                    up_rvalid = 1'b1;
                    pop       = 1'b1;
                    upd_en    = 1'b1;
                end else if (head_vld) begin
                    dn_req = dn_rdy;
                    if (dn_rdy) state_d = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (dn_rvalid) begin
                    up_rvalid = 1'b1;
                    up_rdata  = dn_rdata[word_idx*CPU_W +: CPU_W];
                    pop       = 1'b1;
                    upd_en    = 1'b1;
                    upd_fill  = 1'b1;
                    upd_way   = victim;
                    ln_wr     = 1'b1;
                    ln_way    = victim;
                    ln_data   = dn_rdata;
                    ln_be     = '1;
                    state_d   = ST_SERVE;
                end
            end
            default: state_d = ST_SERVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SERVE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
    parameter int MEM_BYTES = 16,
    parameter int CPU_BYTES = 4,
    parameter int PENDING   = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 up_req,
    input logic                 up_rdy,
    input logic                 up_rvalid,
    input logic                 dn_req,
    input logic                 dn_wr,
    input logic                 dn_rdy,
    input logic [MEM_BYTES-1:0] dn_be
);

    // R9
    dn_req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> dn_rdy);

    // R9
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_wr) |=> !dn_req);

    // R6
    be_span_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_wr) |-> ($countones(dn_be) <= CPU_BYTES));

    // R1
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        up_rvalid |-> !dn_req);

    // R11
    single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (PENDING == 1 && up_req && up_rdy) |=> !up_rdy);

    // R12
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (up_rdy && !up_rvalid && !dn_req));

endmodule

bind wtc_cache wtc_cache_chk #(
    .MEM_BYTES(MEM_W / 8), .CPU_BYTES(CPU_W / 8), .PENDING(PENDING)
) u_chk (
    .clk(clk), .rst(rst), .up_req(up_req), .up_rdy(up_rdy), .up_rvalid(up_rvalid),
    .dn_req(dn_req), .dn_wr(dn_wr), .dn_rdy(dn_rdy), .dn_be(dn_be)
);

// File: tb/wtc_cache_tb.sv
module wtc_cache_tb;

    localparam int CPU_W = 32;
    localparam int MEM_W = 128;

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
        logic        miss;
        logic [1:0]  kind;
    } vec_t;

    // kind: 0 packing, 1 LRU, 2 no-allocate, 3 write-through
    localparam vec_t VECS [20] = '{
        '{1'b0, 10'd0,    32'h0,        4'h0, 32'h10000000, 1'b1, 2'd0},
        '{1'b0, 10'd3,    32'h0,        4'h0, 32'h10000003, 1'b0, 2'd0},
        '{1'b0, 10'd17,   32'h0,        4'h0, 32'h10000011, 1'b1, 2'd1},
        '{1'b0, 10'd1,    32'h0,        4'h0, 32'h10000001, 1'b0, 2'd1},
        '{1'b0, 10'd34,   32'h0,        4'h0, 32'h10000022, 1'b1, 2'd1},
        '{1'b0, 10'd2,    32'h0,        4'h0, 32'h10000002, 1'b0, 2'd1},
        '{1'b0, 10'd16,   32'h0,        4'h0, 32'h10000010, 1'b1, 2'd1},
        '{1'b0, 10'd33,   32'h0,        4'h0, 32'h10000021, 1'b1, 2'd1},
        '{1'b0, 10'd0,    32'h0,        4'h0, 32'h10000000, 1'b1, 2'd1},
        '{1'b1, 10'd1,    32'hDEADBEEF, 4'hF, 32'h0,        1'b0, 2'd3},
        '{1'b0, 10'd1,    32'h0,        4'h0, 32'hDEADBEEF, 1'b0, 2'd3},
        '{1'b1, 10'd2,    32'hAABBCCDD, 4'h5, 32'h0,        1'b0, 2'd3},
        '{1'b0, 10'd2,    32'h0,        4'h0, 32'h10BB00DD, 1'b0, 2'd3},
        '{1'b1, 10'd100,  32'h12345678, 4'hF, 32'h0,        1'b0, 2'd2},
        '{1'b0, 10'd100,  32'h0,        4'h0, 32'h12345678, 1'b1, 2'd2},
        '{1'b0, 10'd101,  32'h0,        4'h0, 32'h10000065, 1'b0, 2'd0},
        '{1'b1, 10'd203,  32'hFFFFFFFF, 4'h8, 32'h0,        1'b0, 2'd2},
        '{1'b0, 10'd203,  32'h0,        4'h0, 32'hFF0000CB, 1'b1, 2'd2},
        '{1'b0, 10'd1023, 32'h0,        4'h0, 32'h100003FF, 1'b1, 2'd0},
        '{1'b0, 10'd1020, 32'h0,        4'h0, 32'h100003FC, 1'b0, 2'd0}
    };

    localparam logic [9:0]  STREAM_A [8] = '{10'd0, 10'd1, 10'd2, 10'd3, 10'd3, 10'd2, 10'd1, 10'd0};
    localparam logic [31:0] STREAM_D [8] = '{32'h10000000, 32'hDEADBEEF, 32'h10BB00DD, 32'h10000003,
                                            32'h10000003, 32'h10BB00DD, 32'hDEADBEEF, 32'h10000000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         up_req = 1'b0, up_wr = 1'b0;
    logic [9:0]   up_addr = '0;
    logic [31:0]  up_wdata = '0;
    logic [3:0]   up_be = '0;
    logic         up_rdy, up_rvalid;
    logic [31:0]  up_rdata;
    logic         dn_req, dn_wr, dn_rvalid;
    logic         dn_rdy = 1'b1;
    logic [7:0]   dn_addr;
    logic [127:0] dn_wdata, dn_rdata;
    logic [15:0]  dn_be;

    logic         one_req = 1'b0;
    logic         one_rdy, one_rvalid, one_dreq, one_dwr;
    logic [31:0]  one_rdata;
    logic [7:0]   one_daddr;
    logic [127:0] one_dwdata;
    logic [15:0]  one_dbe;

    wtc_cache #(.LINES(8), .WAYS(2), .CPU_W(CPU_W), .MEM_AW(8), .MEM_W(MEM_W), .PENDING(2)) u_dut (
        .clk(clk), .rst(rst), .up_req(up_req), .up_wr(up_wr), .up_addr(up_addr),
        .up_wdata(up_wdata), .up_be(up_be), .up_rdy(up_rdy), .up_rvalid(up_rvalid),
        .up_rdata(up_rdata), .dn_req(dn_req), .dn_wr(dn_wr), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_be(dn_be), .dn_rdy(dn_rdy), .dn_rvalid(dn_rvalid),
        .dn_rdata(dn_rdata)
    );

    wtc_cache #(.LINES(8), .WAYS(2), .CPU_W(CPU_W), .MEM_AW(8), .MEM_W(MEM_W), .PENDING(1)) u_one (
        .clk(clk), .rst(rst), .up_req(one_req), .up_wr(1'b1), .up_addr(10'd5),
        .up_wdata(32'h0BADF00D), .up_be(4'hF), .up_rdy(one_rdy), .up_rvalid(one_rvalid),
        .up_rdata(one_rdata), .dn_req(one_dreq), .dn_wr(one_dwr), .dn_addr(one_daddr),
        .dn_wdata(one_dwdata), .dn_be(one_dbe), .dn_rdy(1'b1), .dn_rvalid(1'b0),
        .dn_rdata(128'h0)
    );

    // memory model: two-cycle read latency
    logic [127:0] store [256];
    logic         p0_v, p1_v;
    logic [7:0]   p0_a, p1_a;
    int           rd_cnt, wr_cnt, gate_viol;
    logic [15:0]  last_be;
    logic [127:0] last_wd;

    always @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < 256; l++)
                for (int k = 0; k < 4; k++)
                    store[l][32*k +: 32] <= 32'h10000000 + 32'(4*l + k);
            p0_v <= 1'b0; p1_v <= 1'b0; p0_a <= '0; p1_a <= '0;
            rd_cnt <= 0; wr_cnt <= 0;
        end else begin
            p1_v <= p0_v; p1_a <= p0_a; p0_v <= 1'b0;
            if (dn_req && !dn_rdy) gate_viol <= gate_viol + 1;
            if (dn_req && !dn_wr) begin
                p0_v <= 1'b1; p0_a <= dn_addr; rd_cnt <= rd_cnt + 1;
            end
            if (dn_req && dn_wr) begin
                for (int b = 0; b < 16; b++)
                    if (dn_be[b]) store[dn_addr][8*b +: 8] <= dn_wdata[8*b +: 8];
                wr_cnt <= wr_cnt + 1; last_be <= dn_be; last_wd <= dn_wdata;
            end
        end
    end

    assign dn_rvalid = p1_v;
    assign dn_rdata  = store[p1_a];

    int cyc = 0;
    logic throttle = 1'b0;
    always @(negedge clk) begin
        cyc++;
        dn_rdy = throttle ? ((cyc % 3) != 2) : 1'b1;
    end

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd1:    return "R8 victim order";
            2'd2:    return "R5 no allocate";
            2'd3:    return "R4 write through";
            default: return "R3 word packing";
        endcase
    endfunction

    task automatic issue(input logic wr, input logic [9:0] a, input logic [31:0] d, input logic [3:0] m);
        up_req = 1'b1; up_wr = wr; up_addr = a; up_wdata = d; up_be = m;
        while (!up_rdy) @(negedge clk);
        @(negedge clk);
        up_req = 1'b0;
    endtask

    task automatic run_read(input logic [9:0] a, input logic [31:0] exp, input logic miss, input string tag);
        int base;
        base = rd_cnt;
        issue(1'b0, a, 32'h0, 4'h0);
        while (!up_rvalid) @(negedge clk);
        check(up_rdata == exp, tag, up_rdata, exp);
        @(negedge clk);
        check((rd_cnt - base) == int'(miss), miss ? "R2 memory reads" : "R1 memory reads",
              rd_cnt - base, int'(miss));
    endtask

    task automatic run_write(input logic [9:0] a, input logic [31:0] d, input logic [3:0] m);
        int base;
        logic [15:0] exp_be;
        base = wr_cnt;
        exp_be = 16'(m) << (4 * (a % 4));
        issue(1'b1, a, d, m);
        while (wr_cnt == base) @(negedge clk);
        check(last_be == exp_be, "R6 byte enables", last_be, exp_be);
        check(last_wd == {4{d}}, "R4 write data", last_wd, {4{d}});
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    logic        mon_on = 1'b0;
    int          got_n = 0;
    logic [31:0] got [8];
    always @(negedge clk) begin
        if (mon_on && up_rvalid && got_n < 8) begin
            got[got_n] = up_rdata;
            got_n++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R9 watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int acc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(up_rdy == 1'b1, "R12 rdy after reset", up_rdy, 1);
        check(up_rvalid == 1'b0, "R12 strobe after reset", up_rvalid, 0);
        check(dn_req == 1'b0, "R12 mem idle after reset", dn_req, 0);
        throttle = 1'b1;

        for (int i = 0; i < 20; i++) begin
            if (VECS[i].wr) run_write(VECS[i].addr, VECS[i].wdata, VECS[i].be);
            else            run_read(VECS[i].addr, VECS[i].exp, VECS[i].miss, kind_tag(VECS[i].kind));
        end

        // back-to-back hits, ordered return
        throttle = 1'b0;
        mon_on = 1'b1;
        for (int i = 0; i < 8; i++) begin
            up_req = 1'b1; up_wr = 1'b0; up_addr = STREAM_A[i];
            check(up_rdy == 1'b1, "R10 rdy in stream", up_rdy, 1);
            @(negedge clk);
        end
        up_req = 1'b0;
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        check(got_n == 8, "R10 stream count", got_n, 8);
        for (int i = 0; i < 8; i++)
            check(got[i] == STREAM_D[i], "R7 return order", got[i], STREAM_D[i]);

        // single-register buffering rate
        acc = 0;
        one_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (i == 1) check(one_rdy == 1'b0, "R11 rdy after accept", one_rdy, 0);
            if (one_rdy) acc++;
            @(negedge clk);
        end
        one_req = 1'b0;
        check(acc == 3, "R11 accept rate", acc, 3);

        check(gate_viol == 0, "R9 request gating", gate_viol, 0);

        // reset invalidates: cached line misses again
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(up_rdy == 1'b1, "R12 rdy after second reset", up_rdy, 1);
        run_read(10'd3, 32'h10000003, 1'b1, "R12 invalidated line");
        run_read(10'd2, 32'h10000002, 1'b0, "R2 refill then hit");

        finish_run();
    end

    initial gate_viol = 0;

endmodule